// File: doc/BRIEF.md
# Four-Mode Addressable Output Latch

This block holds a bank of output bits, each of which models a low-side open-drain switch. A binary select addresses one bit at a time, a single data line supplies the value, and two active-low controls pick the mode. `en_n` is the enable and `clr_n` is the clear. The four modes are:

- **Write:** the addressed bit is written and all other bits are kept.
- **Hold:** every bit is frozen.
- **Demultiplex:** the data value is steered onto the addressed output only, and all other outputs are forced off. The stored bits are not changed.
- **Clear:** every output is switched off and the stored bits are wiped.

For each output there are two views. `drain_on` reports whether the switch conducts. `pin_level` is the level the pin would read, which is low while the switch conducts. The storage elements are modelled as registers on the system clock. The inputs are sampled on the rising edge, and both output vectors are registered in the same edge as the stored state.

Top module: `addr_out_latch`

## Requirements
- R1: With `clr_n`=1 and `en_n`=0, the stored bit picked by `sel` takes the value of `din` at the rising edge, and `drain_on` shows the updated store after that edge.
- R2: In write mode, every stored bit other than the addressed one keeps its previous value.
- R3: With `clr_n`=1 and `en_n`=1, `drain_on` shows the stored bits unchanged, whatever the values on `sel` and `din`.
- R4: With `clr_n`=0 and `en_n`=0, `drain_on` bit `sel` equals `din` after the edge, and all other `drain_on` bits are 0.
- R5: Demultiplex mode does not alter the stored bits. On return to hold mode, `drain_on` again shows the stored contents.
- R6: With `clr_n`=0 and `en_n`=1, `drain_on` becomes all zeros and the store is zeroed, whatever the values on `sel` and `din`.
- R7: `sel` is a plain binary index with its MSB most significant. Value 0 addresses `drain_on[0]`, and value NUM_OUTS-1 addresses the top bit.
- R8: `pin_level` is always the bitwise inverse of `drain_on`. A 1 on `drain_on` (switch sinking) reads as pin level 0.
- R9: The synchronous active-high `rst` zeroes the store and `drain_on`, and drives `pin_level` to all ones, from the edge at which it is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | SEL_W | Binary address of the output bit |
| din | input | 1 | Data bit to write or to steer |
| en_n | input | 1 | Enable, active low |
| clr_n | input | 1 | Clear, active low |
| drain_on | output | NUM_OUTS | 1 where the modelled switch conducts |
| pin_level | output | NUM_OUTS | Modelled pin level, inverse of `drain_on` |

## Verification
The checker assumes that `sel` never changes between two consecutive cycles in which `en_n` is low. This is the rule that prevents a transient address from writing the wrong bit, and the checker flags any breach of it.

The bench keeps to this rule by doing every operation as a three-cycle frame:

1. `en_n` is high while the new address is put on `sel`.
2. One cycle follows with the enable asserted.
3. `en_n` returns high before the address moves again.

Free changes of `sel` and `din` occur only in hold and clear cycles, where the enable is off.

// File: rtl/aol_pkg.sv
package aol_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } aol_mode_e;
endpackage

// File: rtl/aol_mode_dec.sv
module aol_mode_dec
  import aol_pkg::*;
(
  input  logic      clr_n,
  input  logic      en_n,
  output aol_mode_e mode
);
  always_comb begin
    unique case ({clr_n, en_n})
      2'b10:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/aol_sel_dec.sv
module aol_sel_dec #(
  parameter int NUM_OUTS = 8,
  parameter int SEL_W    = $clog2(NUM_OUTS)
) (
  input  logic [SEL_W-1:0]    sel,
  output logic [NUM_OUTS-1:0] onehot
);
  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_dec
    assign onehot[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/aol_latch_bank.sv
module aol_latch_bank
  import aol_pkg::*;
#(
  parameter int NUM_OUTS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  aol_mode_e           mode,
  input  logic [NUM_OUTS-1:0] onehot,
  input  logic                din,
  output logic [NUM_OUTS-1:0] store_d,
  output logic [NUM_OUTS-1:0] store_q
);
  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_bit
    always_comb begin
      case (mode)
        MODE_WRITE: store_d[i] = onehot[i] ? din : store_q[i];
        MODE_CLEAR: store_d[i] = 1'b0;
        default:    store_d[i] = store_q[i];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) store_q[i] <= 1'b0;
      else     store_q[i] <= store_d[i];
    end
  end
endmodule

// File: rtl/aol_out_stage.sv
module aol_out_stage
  import aol_pkg::*;
#(
  parameter int NUM_OUTS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  aol_mode_e           mode,
  input  logic [NUM_OUTS-1:0] onehot,
  input  logic                din,
  input  logic [NUM_OUTS-1:0] store_d,
  output logic [NUM_OUTS-1:0] drain_q,
  output logic [NUM_OUTS-1:0] pin_q
);
  logic [NUM_OUTS-1:0] drive_d;

  always_comb begin
    if (mode == MODE_DEMUX) drive_d = onehot & {NUM_OUTS{din}};
    else                    drive_d = store_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_q <= '0;
      pin_q   <= '1;
    end else begin
      drain_q <= drive_d;
      pin_q   <= ~drive_d;
    end
  end
endmodule

// File: rtl/addr_out_latch.sv
module addr_out_latch
  import aol_pkg::*;
#(
  parameter int NUM_OUTS = 8,
  localparam int SEL_W   = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    sel,
  input  logic                din,
  input  logic                en_n,
  input  logic                clr_n,
  output logic [NUM_OUTS-1:0] drain_on,
  output logic [NUM_OUTS-1:0] pin_level
);
  aol_mode_e           mode;
  logic [NUM_OUTS-1:0] onehot;
  logic [NUM_OUTS-1:0] store_d;
  logic [NUM_OUTS-1:0] store_q;

  aol_mode_dec u_mode (
    .clr_n (clr_n),
    .en_n  (en_n),
    .mode  (mode)
  );

  aol_sel_dec #(.NUM_OUTS(NUM_OUTS), .SEL_W(SEL_W)) u_dec (
    .sel    (sel),
    .onehot (onehot)
  );

  aol_latch_bank #(.NUM_OUTS(NUM_OUTS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .onehot  (onehot),
    .din     (din),
    .store_d (store_d),
    .store_q (store_q)
  );

  aol_out_stage #(.NUM_OUTS(NUM_OUTS)) u_out (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .onehot  (onehot),
    .din     (din),
    .store_d (store_d),
    .drain_q (drain_on),
    .pin_q   (pin_level)
  );
endmodule

// File: rtl/aol_checker.sv
module aol_checker #(
  parameter int NUM_OUTS = 8,
  parameter int SEL_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [SEL_W-1:0]    sel,
  input logic                din,
  input logic                en_n,
  input logic                clr_n,
  input logic [NUM_OUTS-1:0] drain_on,
  input logic [NUM_OUTS-1:0] pin_level
);
  logic [1:0] age;
  logic       ticked;

  always_ff @(posedge clk) begin
    ticked <= 1'b1;
    if (rst)             age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R8
  a_r8_pin_inverse: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> (pin_level == ~drain_on));

  // R9
  a_r9_reset_state: assert property (@(posedge clk)
    (ticked && $past(rst)) |-> (drain_on == '0 && pin_level == '1));

  // R1
  a_r1_write_bit: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $past(clr_n) && !$past(en_n))
      |-> (drain_on[$past(sel)] == $past(din)));

  // R2: needs the cycle before the write to have shown the store too
  a_r2_others_kept: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(clr_n) && !$past(en_n) && $past(clr_n, 2))
      |-> (((drain_on ^ $past(drain_on))
            & ~({{(NUM_OUTS-1){1'b0}}, 1'b1} << $past(sel))) == '0));

  // R3
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(clr_n) && $past(en_n) && $past(clr_n, 2))
      |-> $stable(drain_on));

  // R4
  a_r4_demux_route: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !$past(clr_n) && !$past(en_n))
      |-> ($countones(drain_on) <= 1 && drain_on[$past(sel)] == $past(din)));

  // R6
  a_r6_clear_off: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !$past(clr_n) && $past(en_n)) |-> (drain_on == '0));

  // input rule: address frozen across back-to-back enabled cycles
  a_in_sel_frozen: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !en_n && !$past(en_n)) |-> $stable(sel));
endmodule

bind addr_out_latch aol_checker #(.NUM_OUTS(NUM_OUTS), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/test_addr_out_latch.sv
module test_addr_out_latch;
  localparam int PERIOD = 10;
  localparam int NUM    = 8;
  localparam int SW     = 3;

  logic           clk = 1'b0;
  logic           rst;
  logic [SW-1:0]  sel;
  logic           din;
  logic           en_n;
  logic           clr_n;
  logic [NUM-1:0] drain_on;
  logic [NUM-1:0] pin_level;

  logic [NUM-1:0] exp_store;
  logic [NUM-1:0] exp_out;
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  addr_out_latch #(.NUM_OUTS(NUM)) i_addr_out_latch (
    .clk(clk), .rst(rst), .sel(sel), .din(din), .en_n(en_n), .clr_n(clr_n),
    .drain_on(drain_on), .pin_level(pin_level)
  );

  task automatic check(input string tag, input logic [NUM-1:0] act, input logic [NUM-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, sample at next negedge
  task automatic apply(input logic c, input logic e, input logic [SW-1:0] s,
                       input logic d, input string tag);
    clr_n = c; en_n = e; sel = s; din = d;
    @(posedge clk);
    case ({c, e})
      2'b10: begin exp_store[s] = d; exp_out = exp_store; end
      2'b11: exp_out = exp_store;
      2'b00: exp_out = NUM'(d) << s;
      default: begin exp_store = '0; exp_out = '0; end
    endcase
    @(negedge clk);
    check(tag, drain_on, exp_out);
    check("R8 pin", pin_level, ~exp_out);
  endtask

  task automatic do_write(input logic [SW-1:0] s, input logic d, input string tag);
    apply(1'b1, 1'b1, s, 1'b0, "R3 pre");
    apply(1'b1, 1'b0, s, d, tag);
    apply(1'b1, 1'b1, s, ~d, "R3 post");
  endtask

  task automatic do_demux(input logic [SW-1:0] s, input logic d);
    apply(1'b1, 1'b1, s, 1'b0, "R3 pre");
    apply(1'b0, 1'b0, s, d, "R4 demux");
    apply(1'b1, 1'b1, s, ~d, "R5 restore");
  endtask

  initial begin
    rst = 1'b1; sel = '0; din = 1'b0; en_n = 1'b1; clr_n = 1'b1;
    exp_store = '0; exp_out = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 reset drain", drain_on, '0);
    check("R9 reset pin", pin_level, '1);
    rst = 1'b0;

    // R7: single bit per address from a cleared store
    for (int s = 0; s < NUM; s++) begin
      apply(1'b0, 1'b1, SW'(s), 1'b1, "R6 clear");
      do_write(SW'(s), 1'b1, "R7 index");
      check("R7 onehot", drain_on, NUM'(1) << s);
    end

    // R1/R2: build patterns bit by bit, then overwrite
    apply(1'b0, 1'b1, '0, 1'b0, "R6 clear");
    for (int s = 0; s < NUM; s++) do_write(SW'(s), 1'((s * 5 + 1) >> 1), "R1 write");
    for (int s = NUM - 1; s >= 0; s--) do_write(SW'(s), ~exp_store[s], "R2 others");
    for (int s = 0; s < NUM; s += 3) do_write(SW'(s), exp_store[s], "R2 rewrite");

    // R3: hold ignores free-running address and data
    for (int k = 0; k < 16; k++) apply(1'b1, 1'b1, SW'(k * 3), 1'(k), "R3 hold");

    // R4/R5: every address with both data values
    for (int s = 0; s < NUM; s++) begin
      do_demux(SW'(s), 1'b1);
      do_demux(SW'(s), 1'b0);
    end

    // R6: clear ignores address and data, store gone afterwards
    for (int k = 0; k < 4; k++) apply(1'b0, 1'b1, SW'(k * 5), 1'(k), "R6 clear");
    for (int k = 0; k < 4; k++) apply(1'b1, 1'b1, SW'(k), 1'b1, "R6 store zero");

    // R9: reset in the middle of use
    do_write(SW'(NUM - 1), 1'b1, "R1 write");
    do_write(SW'(2), 1'b1, "R1 write");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    exp_store = '0; exp_out = '0;
    check("R9 mid reset drain", drain_on, '0);
    check("R9 mid reset pin", pin_level, '1);
    rst = 1'b0;
    apply(1'b1, 1'b1, '0, 1'b0, "R9 store zero");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule